// File: doc/BRIEF.md
# Four-Channel Low-Side Driver Fault Controller

This block is the digital sequencer behind a four-channel low-side switch driver. Each channel's logic command drives its gate-enable output directly, provided that the shared active-low enable is low and nothing has shut the channel off. The analog parts of the driver report events to the block as plain flags: a per-channel current-limit flag, a die over-temperature flag and a supply-undervoltage flag.

Each channel has its own small state machine. A current-limit flag that stays high for a parameterised number of cycles trips the channel. A tripped channel turns its gate off and pulls the shared active-low fault output low. After a parameterised retry time the channel clears itself. Over-temperature switches every gate off and pulls the fault output low for as long as the flag stays high. Undervoltage and the active-high clear input both reset all internal state at once and hold the outputs off.

Every asynchronous input passes through a two-stage synchronizer before any logic uses it, so inputs take effect two clocks after they are captured. The timer lengths are given in clock cycles. The defaults correspond to roughly 3.5 us of deglitch time and 1.2 ms of retry time at 100 MHz. All control pins are level signals with no handshake.

Top module: `lsd_fault_ctrl`

## Requirements
- R1: When enabled and with no fault, shutdown or clear active, gate_en[i] equals the synchronized cmd_in[i] for each channel independently.
- R2: While en_n is high (synchronized), all gate_en bits are 0.
- R3: When oc_flag[i] has been high for DEG_CYC consecutive synchronized cycles, channel i trips: gate_en[i] goes to 0 and fault_n goes low. The trip happens two clocks plus DEG_CYC clocks after the flag is captured, and the other channels keep following their commands.
- R4: An oc_flag[i] pulse shorter than DEG_CYC cycles records no fault, and the deglitch count restarts from zero after every drop of the flag. Two pulses of DEG_CYC-1 cycles separated by a gap therefore never trip the channel.
- R5: A tripped channel stays off, with fault_n low, for exactly RET_CYC cycles, then clears itself and follows its command again.
- R6: While clr is high (synchronized), all gates are 0, fault_n is 1 and all commands are ignored. Any trip is cleared at once.
- R7: While ot_flag is high (synchronized), all gates are 0 and fault_n is 0. Normal operation resumes when the flag drops.
- R8: While uv_flag is high (synchronized), all gates are 0, fault_n is 1 and all channel state is reset. Normal operation resumes when the flag drops.
- R9: Every input takes effect on the outputs two clock edges after it is applied: the output has not changed after one edge and has changed after two.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous power-up reset |
| cmd_in | input | NCH | Per-channel logic command |
| en_n | input | 1 | Active-low output enable |
| clr | input | 1 | Active-high logic clear |
| oc_flag | input | NCH | Per-channel current-limit flag |
| ot_flag | input | 1 | Over-temperature flag |
| uv_flag | input | 1 | Supply-undervoltage flag |
| gate_en | output | NCH | Per-channel gate enable |
| fault_n | output | 1 | Active-low fault indication |

## Verification
The bench holds a current-limit pulse one cycle short of the deglitch time, twice with a gap between the pulses. A counter that failed to restart, or that compared one too early, would trip there. It then measures the cycle in which a trip appears and the exact length of the retry window; an off-by-one in either timer shows up as a wrong count. Clear and undervoltage are applied while a channel is tripped, to catch a design that keeps the fault until the retry ends. A single-channel trip with the other channels commanded on exposes any leak between channels.

// File: rtl/lsd_pkg.sv
package lsd_pkg;
  typedef enum logic {CH_RUN = 1'b0, CH_RETRY = 1'b1} ch_state_t;
endpackage

// File: rtl/lsd_sync.sv
module lsd_sync #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta <= '0;
      q    <= '0;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/lsd_chan.sv
module lsd_chan
  import lsd_pkg::*;
#(
  parameter int DEG_CYC = 350,
  parameter int RET_CYC = 120000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic soft_rst,
  input  logic oc,
  output logic retry
);
  localparam int DW = $clog2(DEG_CYC + 1);
  localparam int RW = $clog2(RET_CYC + 1);
  localparam logic [DW-1:0] DEG_LAST = DW'(DEG_CYC - 1);
  localparam logic [RW-1:0] RET_LAST = RW'(RET_CYC - 1);

  ch_state_t     st;
  logic [DW-1:0] deg_cnt;
  logic [RW-1:0] ret_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= CH_RUN;
      deg_cnt <= '0;
      ret_cnt <= '0;
    end else if (soft_rst) begin
      st      <= CH_RUN;
      deg_cnt <= '0;
      ret_cnt <= '0;
    end else begin
      case (st)
        CH_RUN: begin
          ret_cnt <= '0;
          if (!oc) begin
            deg_cnt <= '0;
          end else if (deg_cnt == DEG_LAST) begin
            deg_cnt <= '0;
            st      <= CH_RETRY;
          end else begin
            deg_cnt <= deg_cnt + 1'b1;
          end
        end
        default: begin
          deg_cnt <= '0;
          if (ret_cnt == RET_LAST) begin
            ret_cnt <= '0;
            st      <= CH_RUN;
          end else begin
            ret_cnt <= ret_cnt + 1'b1;
          end
        end
      endcase
    end
  end

  assign retry = (st == CH_RETRY);
endmodule

// File: rtl/lsd_fault_ctrl.sv
module lsd_fault_ctrl #(
  parameter int NCH     = 4,
  parameter int DEG_CYC = 350,
  parameter int RET_CYC = 120000
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] cmd_in,
  input  logic           en_n,
  input  logic           clr,
  input  logic [NCH-1:0] oc_flag,
  input  logic           ot_flag,
  input  logic           uv_flag,
  output logic [NCH-1:0] gate_en,
  output logic           fault_n
);
  localparam int SW = 2 * NCH + 4;

  logic [SW-1:0]  raw_in;
  logic [SW-1:0]  syn;
  logic [NCH-1:0] in_s;
  logic [NCH-1:0] oc_s;
  logic           en_s;
  logic           clr_s;
  logic           ot_s;
  logic           uv_s;
  logic           soft_rst;
  logic [NCH-1:0] retry;
  logic           drive_ok;

  assign raw_in = {uv_flag, ot_flag, clr, en_n, oc_flag, cmd_in};

  lsd_sync #(.W(SW)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d    (raw_in),
    .q    (syn)
  );

  assign in_s  = syn[NCH-1:0];
  assign oc_s  = syn[2*NCH-1:NCH];
  assign en_s  = syn[2*NCH];
  assign clr_s = syn[2*NCH+1];
  assign ot_s  = syn[2*NCH+2];
  assign uv_s  = syn[2*NCH+3];

  assign soft_rst = clr_s | uv_s;

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    lsd_chan #(.DEG_CYC(DEG_CYC), .RET_CYC(RET_CYC)) u_chan (
      .clk     (clk),
      .rst_n   (rst_n),
      .soft_rst(soft_rst),
      .oc      (oc_s[i]),
      .retry   (retry[i])
    );
  end

  assign drive_ok = ~en_s & ~ot_s & ~soft_rst;
  assign gate_en  = in_s & ~retry & {NCH{drive_ok}};
  assign fault_n  = ~(((|retry) | ot_s) & ~soft_rst);
endmodule

// File: rtl/lsd_fault_chk.sv
module lsd_fault_chk #(
  parameter int NCH = 4
) (
  input logic           clk,
  input logic           rst_n,
  input logic [NCH-1:0] gate_en,
  input logic           fault_n,
  input logic [NCH-1:0] in_s,
  input logic           en_s,
  input logic           ot_s,
  input logic           soft_rst,
  input logic [NCH-1:0] retry
);
  a_r1_gate_needs_cmd: assert property (@(posedge clk) disable iff (!rst_n)
    (gate_en & ~in_s) == '0);

  a_r2_disabled_off: assert property (@(posedge clk) disable iff (!rst_n)
    en_s |-> gate_en == '0);

  a_r3_tripped_off: assert property (@(posedge clk) disable iff (!rst_n)
    (gate_en & retry) == '0);

  a_r5_trip_flags_fault: assert property (@(posedge clk) disable iff (!rst_n)
    ((retry != '0) && !soft_rst) |-> !fault_n);

  a_r6_clear_resets: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> retry == '0);

  a_r6_clear_outputs: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |-> (gate_en == '0 && fault_n));

  a_r7_thermal: assert property (@(posedge clk) disable iff (!rst_n)
    (ot_s && !soft_rst) |-> (!fault_n && gate_en == '0));
endmodule

bind lsd_fault_ctrl lsd_fault_chk #(.NCH(NCH)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .gate_en (gate_en),
  .fault_n (fault_n),
  .in_s    (in_s),
  .en_s    (en_s),
  .ot_s    (ot_s),
  .soft_rst(soft_rst),
  .retry   (retry)
);

// File: tb/sim_lsd_fault_ctrl.sv
module sim_lsd_fault_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int NCH = 4;
  localparam int DEG = 8;
  localparam int RET = 40;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic [NCH-1:0] cmd_in = '0;
  logic           en_n = 1'b0;
  logic           clr = 1'b0;
  logic [NCH-1:0] oc_flag = '0;
  logic           ot_flag = 1'b0;
  logic           uv_flag = 1'b0;
  logic [NCH-1:0] gate_en;
  logic           fault_n;

  int n_run = 0;
  int n_fail = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  lsd_fault_ctrl #(.NCH(NCH), .DEG_CYC(DEG), .RET_CYC(RET)) u0 (
    .clk(clk), .rst_n(rst_n), .cmd_in(cmd_in), .en_n(en_n), .clr(clr),
    .oc_flag(oc_flag), .ot_flag(ot_flag), .uv_flag(uv_flag),
    .gate_en(gate_en), .fault_n(fault_n)
  );

  // {cmd, en_n, ot, expected gate, expected fault_n}
  localparam logic [10:0] VEC [8] = '{
    {4'hF, 1'b0, 1'b0, 4'hF, 1'b1},  // R1
    {4'h5, 1'b0, 1'b0, 4'h5, 1'b1},  // R1
    {4'hA, 1'b0, 1'b0, 4'hA, 1'b1},  // R1
    {4'h0, 1'b0, 1'b0, 4'h0, 1'b1},  // R1
    {4'hF, 1'b1, 1'b0, 4'h0, 1'b1},  // R2
    {4'h3, 1'b1, 1'b0, 4'h0, 1'b1},  // R2
    {4'hF, 1'b0, 1'b1, 4'h0, 1'b0},  // R7
    {4'h9, 1'b0, 1'b0, 4'h9, 1'b1}   // R7 recovery
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    int first_low;
    int low_cnt;
    wait_n(3);
    chk("R1 reset gate", 32'(gate_en), 0);
    chk("R1 reset fault_n", 32'(fault_n), 1);
    rst_n = 1'b1;
    wait_n(2);

    // R9: two-edge latency
    cmd_in = 4'hF;
    wait_n(1);
    chk("R9 after one edge", 32'(gate_en), 0);
    wait_n(1);
    chk("R9 after two edges", 32'(gate_en), 32'hF);

    for (int v = 0; v < 8; v++) begin
      cmd_in  = VEC[v][10:7];
      en_n    = VEC[v][6];
      ot_flag = VEC[v][5];
      wait_n(3);
      chk($sformatf("R1/R2/R7 vec%0d gate", v), 32'(gate_en), 32'(VEC[v][4:1]));
      chk($sformatf("R1/R2/R7 vec%0d fault_n", v), 32'(fault_n), 32'(VEC[v][0]));
    end

    // R4: short pulses never trip
    cmd_in = 4'hF;
    wait_n(3);
    oc_flag = 4'h1; wait_n(DEG-1);
    oc_flag = 4'h0; wait_n(3);
    oc_flag = 4'h1; wait_n(DEG-1);
    oc_flag = 4'h0;
    for (int k = 0; k < 6; k++) begin
      wait_n(1);
      if (!fault_n) begin
        chk("R4 short pulse no trip", 32'(fault_n), 1);
        break;
      end
    end
    chk("R4 gate still on", 32'(gate_en), 32'hF);

    // R3 / R5: trip timing and retry length on channel 1
    first_low = 0;
    low_cnt = 0;
    oc_flag = 4'h2;
    for (int k = 1; k <= 200; k++) begin
      @(negedge clk);
      if (!fault_n) begin
        if (first_low == 0) begin
          first_low = k;
          chk("R3 only channel 1 off", 32'(gate_en), 32'hD);
        end
        low_cnt++;
      end
      if (k == DEG + 1) oc_flag = 4'h0;
    end
    chk("R3 trip cycle", first_low, DEG + 2);
    chk("R5 retry length", low_cnt, RET);
    chk("R5 channel back", 32'(gate_en), 32'hF);

    // R6: clear during a trip
    oc_flag = 4'h1;
    wait_n(DEG + 4);
    oc_flag = 4'h0;
    chk("R3 channel 0 tripped", 32'(fault_n), 0);
    clr = 1'b1;
    wait_n(3);
    chk("R6 clear fault_n", 32'(fault_n), 1);
    chk("R6 clear gates", 32'(gate_en), 0);
    cmd_in = 4'h6;
    wait_n(3);
    chk("R6 commands ignored", 32'(gate_en), 0);
    clr = 1'b0;
    wait_n(3);
    chk("R6 resume gate", 32'(gate_en), 32'h6);
    chk("R6 trip cleared", 32'(fault_n), 1);

    // R7: thermal shutdown with recovery
    cmd_in = 4'hF;
    ot_flag = 1'b1;
    wait_n(3);
    chk("R7 thermal gates", 32'(gate_en), 0);
    chk("R7 thermal fault_n", 32'(fault_n), 0);
    ot_flag = 1'b0;
    wait_n(3);
    chk("R7 thermal resume", 32'(gate_en), 32'hF);

    // R8: undervoltage during a trip
    oc_flag = 4'h8;
    wait_n(DEG + 4);
    oc_flag = 4'h0;
    chk("R3 channel 3 tripped", 32'(gate_en), 32'h7);
    uv_flag = 1'b1;
    wait_n(3);
    chk("R8 uv gates", 32'(gate_en), 0);
    chk("R8 uv fault_n", 32'(fault_n), 1);
    uv_flag = 1'b0;
    wait_n(3);
    chk("R8 uv resume gate", 32'(gate_en), 32'hF);
    chk("R8 uv state reset", 32'(fault_n), 1);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule